// File: doc/BRIEF.md
# Status register transfer unit

This block carries out the two processor instructions that move status words: copying the current or saved status register into a general register, and writing a general register value or a rotated immediate into either status register under a byte mask. It takes the instruction word, the current and saved status values and the source register data. It returns a register-file update: a general register write, a current-status write or a saved-status write. The result also carries a warning flag for saved-status access in a mode that has no saved register, and an undefined-instruction flag.

Work arrives on a valid/ready input and leaves on a valid/ready output through one result register. The input is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every result output holds its value and no new instruction is taken. Current-status writes leave on the dedicated current-status port, so the register file can switch banks when the mode field changes. The source register index is offered combinationally so the register file can read it in the same cycle.

Mode is `in_cpsr[4:0]`: User is 5'b10000 and System is 5'b11111. Every other value counts as a privileged mode that has a saved status register.

Top module: `psr_xfer_unit`

## Requirements
- R1: An instruction accepted on a rising edge appears with `out_valid` high right after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` and every result output stay unchanged.
- R2: With instruction bits 21:20 = 2'b00 and bit 22 = 0, the result has `gpr_we` = 1, `gpr_idx` = instruction bits 15:12 and `gpr_data` = the whole current status word.
- R3: With bits 21:20 = 2'b00 and bit 22 = 1, `gpr_data` is the whole saved status word, in every mode.
- R4: `src_idx` always equals instruction bits 3:0. With bits 21:20 = 2'b10 and bit 25 = 0, the write operand is `in_rm_data`.
- R5: With bits 21:20 = 2'b10 and bit 25 = 1, the write operand is bits 7:0 zero-extended and rotated right by twice the value of bits 11:8.
- R6: On a write, mask bits 19:16 are applied so that mask bit i (bit 16 + i of the instruction) takes byte i of the operand, where byte 0 is bits 7:0. Bytes whose mask bit is clear keep their old value, and a mask of zero writes the old word back.
- R7: A write with bit 22 = 0 in any mode except User sets `cpsr_we` and drives the merged word on `cpsr_data`.
- R8: In User mode a write sets neither `cpsr_we` nor `spsr_we`.
- R9: A write with bit 22 = 1 sets `spsr_we` and drives the merged word on `spsr_data` only in a mode other than User and System.
- R10: `spsr_warn` is set when bit 22 = 1 and the mode is User or System, on both the read form and the write form. Otherwise it is clear.
- R11: When bits 21:20 are 2'b01 or 2'b11, `undef` is set and all three write enables stay low.
- R12: After reset, `out_valid` = 0 and `in_ready` = 1. Each data output (`gpr_data`, `gpr_idx`, `cpsr_data`, `spsr_data`) reads zero whenever its write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_cpsr | input | 32 | Current status word |
| in_spsr | input | 32 | Saved status word of the current mode |
| in_rm_data | input | 32 | Read data of the source register |
| src_idx | output | 4 | Source register index for the register file read |
| out_valid | output | 1 | Result is held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| gpr_we | output | 1 | General register write enable |
| gpr_idx | output | 4 | General register destination index |
| gpr_data | output | 32 | General register write data |
| cpsr_we | output | 1 | Current status write enable |
| cpsr_data | output | 32 | New current status word |
| spsr_we | output | 1 | Saved status write enable |
| spsr_data | output | 32 | New saved status word |
| spsr_warn | output | 1 | Saved status accessed in User or System mode |
| undef | output | 1 | Operation field is not a transfer encoding |

## Verification
Every result is due exactly one cycle after its acceptance edge, and it stays due for as long as the consumer stalls. The bench drives and samples one nanosecond after each falling edge. At the first falling edge after acceptance it checks that `out_valid` is high, and its monitor compares the queued expected result on every cycle in which a transfer will happen. For stalled cycles the monitor compares the outputs against the previous cycle's values, so a hold failure and a latency failure are both seen at the cycle they occur.

// File: rtl/psr_xfer_pkg.sv
package psr_xfer_pkg;
  localparam int XLEN      = 32;
  localparam int IDX_W     = 4;
  localparam int NBYTES    = XLEN / 8;
  localparam int MODE_W    = 5;
  localparam int IMM_W     = 8;
  localparam int ROT_W     = 4;
  localparam int AMT_W     = $clog2(XLEN);

  localparam logic [MODE_W-1:0] MODE_USER   = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SYSTEM = 5'b11111;

  localparam logic [1:0] OPC_READ  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b10;

  typedef struct packed {
    logic             undef;
    logic             warn;
    logic             gpr_we;
    logic [IDX_W-1:0] gpr_idx;
    logic [XLEN-1:0]  gpr_data;
    logic             cpsr_we;
    logic [XLEN-1:0]  cpsr_data;
    logic             spsr_we;
    logic [XLEN-1:0]  spsr_data;
  } xfer_result_t;
endpackage

// File: rtl/psr_xfer_decode.sv
module psr_xfer_decode
  import psr_xfer_pkg::*;
(
  input  logic [1:0]        opc,
  input  logic              r_bit,
  input  logic              imm_bit,
  input  logic [MODE_W-1:0] mode,
  output logic              is_read,
  output logic              is_write,
  output logic              is_undef,
  output logic              to_spsr,
  output logic              use_imm,
  output logic              privileged,
  output logic              has_spsr
);
  always_comb begin
    is_read    = (opc == OPC_READ);
    is_write   = (opc == OPC_WRITE);
    is_undef   = !is_read && !is_write;
    to_spsr    = r_bit;
    use_imm    = imm_bit;
    privileged = (mode != MODE_USER);
    has_spsr   = privileged && (mode != MODE_SYSTEM);
  end
endmodule

// File: rtl/psr_xfer_operand.sv
module psr_xfer_operand
  import psr_xfer_pkg::*;
(
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm8,
  input  logic [ROT_W-1:0] rot,
  input  logic [XLEN-1:0]  reg_data,
  output logic [XLEN-1:0]  operand
);
  logic [XLEN-1:0]   imm_ext;
  logic [2*XLEN-1:0] doubled;
  logic [2*XLEN-1:0] shifted;
  logic [AMT_W-1:0]  amount;

  always_comb begin
    imm_ext = {{(XLEN-IMM_W){1'b0}}, imm8};
    amount  = AMT_W'({rot, 1'b0});
    doubled = {imm_ext, imm_ext};
    shifted = doubled >> amount;
    operand = use_imm ? shifted[XLEN-1:0] : reg_data;
  end

  // R5: with no rotation the immediate arrives unchanged
  always_comb begin
    if (use_imm && rot == '0) begin
      p_imm_norot_r5: assert (operand == imm_ext);
    end
  end
endmodule

// File: rtl/psr_xfer_merge.sv
module psr_xfer_merge
  import psr_xfer_pkg::*;
(
  input  logic [XLEN-1:0]   old_word,
  input  logic [XLEN-1:0]   new_word,
  input  logic [NBYTES-1:0] byte_mask,
  output logic [XLEN-1:0]   merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = byte_mask[b] ? new_word[b*8 +: 8] : old_word[b*8 +: 8];
  end
endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
  import psr_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_instr,
  input  logic [XLEN-1:0]  in_cpsr,
  input  logic [XLEN-1:0]  in_spsr,
  input  logic [XLEN-1:0]  in_rm_data,
  output logic [IDX_W-1:0] src_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             gpr_we,
  output logic [IDX_W-1:0] gpr_idx,
  output logic [XLEN-1:0]  gpr_data,
  output logic             cpsr_we,
  output logic [XLEN-1:0]  cpsr_data,
  output logic             spsr_we,
  output logic [XLEN-1:0]  spsr_data,
  output logic             spsr_warn,
  output logic             undef
);
  logic is_read, is_write, is_undef, to_spsr, use_imm, privileged, has_spsr;
  logic [XLEN-1:0] operand, target_old, merged;
  xfer_result_t    res_d, res_q;
  logic            accept;
  logic            unused_bits;

  assign unused_bits = ^{in_instr[31:26], in_instr[24:23]};

  psr_xfer_decode u_decode (
    .opc        (in_instr[21:20]),
    .r_bit      (in_instr[22]),
    .imm_bit    (in_instr[25]),
    .mode       (in_cpsr[MODE_W-1:0]),
    .is_read    (is_read),
    .is_write   (is_write),
    .is_undef   (is_undef),
    .to_spsr    (to_spsr),
    .use_imm    (use_imm),
    .privileged (privileged),
    .has_spsr   (has_spsr)
  );

  psr_xfer_operand u_operand (
    .use_imm  (use_imm),
    .imm8     (in_instr[7:0]),
    .rot      (in_instr[11:8]),
    .reg_data (in_rm_data),
    .operand  (operand)
  );

  assign target_old = to_spsr ? in_spsr : in_cpsr;

  psr_xfer_merge u_merge (
    .old_word  (target_old),
    .new_word  (operand),
    .byte_mask (in_instr[19:16]),
    .merged    (merged)
  );

  always_comb begin
    res_d = '0;
    if (is_read) begin
      res_d.gpr_we   = 1'b1;
      res_d.gpr_idx  = in_instr[15:12];
      res_d.gpr_data = target_old;
      res_d.warn     = to_spsr && !has_spsr;
    end else if (is_write) begin
      res_d.warn = to_spsr && !has_spsr;
      if (to_spsr) begin
        if (has_spsr) begin
          res_d.spsr_we   = 1'b1;
          res_d.spsr_data = merged;
        end
      end else if (privileged) begin
        res_d.cpsr_we   = 1'b1;
        res_d.cpsr_data = merged;
      end
    end else begin
      res_d.undef = is_undef;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign src_idx  = in_instr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_q     <= res_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end
  end

  assign gpr_we    = res_q.gpr_we;
  assign gpr_idx   = res_q.gpr_idx;
  assign gpr_data  = res_q.gpr_data;
  assign cpsr_we   = res_q.cpsr_we;
  assign cpsr_data = res_q.cpsr_data;
  assign spsr_we   = res_q.spsr_we;
  assign spsr_data = res_q.spsr_data;
  assign spsr_warn = res_q.warn;
  assign undef     = res_q.undef;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q));

  p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_instr[21:20] == OPC_READ |=> gpr_we && !cpsr_we && !spsr_we);

  p_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_cpsr[MODE_W-1:0] == MODE_USER |=> !cpsr_we && !spsr_we);

  p_system_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_cpsr[MODE_W-1:0] == MODE_SYSTEM |=> !spsr_we);

  p_warn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_instr[22] |=> !spsr_warn);

  p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !gpr_we && !cpsr_we && !spsr_we);

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_we, cpsr_we, spsr_we, undef}));
endmodule

// File: tb/psr_xfer_unit_tb.sv
module psr_xfer_unit_tb;
  localparam int RW = 105;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0, in_cpsr = '0, in_spsr = '0, in_rm_data = '0;
  logic [3:0]  src_idx;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        gpr_we, cpsr_we, spsr_we, spsr_warn, undef;
  logic [3:0]  gpr_idx;
  logic [31:0] gpr_data, cpsr_data, spsr_data;

  int errors = 0;
  int checks = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;
  logic [RW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  psr_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_cpsr(in_cpsr), .in_spsr(in_spsr),
    .in_rm_data(in_rm_data), .src_idx(src_idx), .out_valid(out_valid),
    .out_ready(out_ready), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
    .gpr_data(gpr_data), .cpsr_we(cpsr_we), .cpsr_data(cpsr_data),
    .spsr_we(spsr_we), .spsr_data(spsr_data), .spsr_warn(spsr_warn),
    .undef(undef)
  );

  function automatic logic [RW-1:0] observed();
    return {undef, spsr_warn, gpr_we, gpr_idx, gpr_data,
            cpsr_we, cpsr_data, spsr_we, spsr_data};
  endfunction

  function automatic logic [31:0] enc(input logic [1:0] op, input logic r,
                                      input logic imm, input logic [3:0] mask,
                                      input logic [3:0] rd, input logic [3:0] rot,
                                      input logic [7:0] low8);
    logic [31:0] w;
    w = 32'hE000_0000;
    w[25] = imm; w[22] = r; w[21:20] = op; w[19:16] = mask;
    w[15:12] = rd; w[11:8] = rot; w[7:0] = low8;
    return w;
  endfunction

  function automatic logic [RW-1:0] model(input logic [31:0] ins, input logic [31:0] cp,
                                          input logic [31:0] sp, input logic [31:0] rm);
    logic u, w, gwe, cwe, swe, usr, sys;
    logic [3:0] gi;
    logic [31:0] gd, cd, sd, opnd, old, mg;
    logic [63:0] dbl;
    int amt;
    u = 0; w = 0; gwe = 0; cwe = 0; swe = 0; gi = 0; gd = 0; cd = 0; sd = 0;
    usr = (cp[4:0] == 5'b10000);
    sys = (cp[4:0] == 5'b11111);
    old = ins[22] ? sp : cp;
    amt = 2 * int'(ins[11:8]);
    dbl = {24'h0, ins[7:0], 24'h0, ins[7:0]} >> amt;
    opnd = ins[25] ? dbl[31:0] : rm;
    for (int b = 0; b < 4; b++)
      mg[b*8 +: 8] = ins[16+b] ? opnd[b*8 +: 8] : old[b*8 +: 8];
    if (ins[21:20] == 2'b00) begin
      gwe = 1; gi = ins[15:12]; gd = old; w = ins[22] && (usr || sys);
    end else if (ins[21:20] == 2'b10) begin
      w = ins[22] && (usr || sys);
      if (ins[22]) begin
        if (!usr && !sys) begin swe = 1; sd = mg; end
      end else if (!usr) begin
        cwe = 1; cd = mg;
      end
    end else begin
      u = 1;
    end
    return {u, w, gwe, gi, gd, cwe, cd, swe, sd};
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] ins, input logic [31:0] cp,
                      input logic [31:0] sp, input logic [31:0] rm);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_cpsr = cp; in_spsr = sp; in_rm_data = rm;
    #1;
    check(src_idx == ins[3:0], "R4 src_idx", RW'(src_idx), RW'(ins[3:0]));
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(ins, cp, sp, rm));
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R1 latency", RW'(out_valid), RW'(1));
  endtask

  // Consumer ready pattern
  initial begin
    logic [2:0] cnt = '0;
    forever begin
      @(negedge clk);
      cnt = cnt + 3'd1;
      out_ready = stall_mode ? (cnt[0] ^ cnt[2]) : 1'b1;
    end
  end

  // Monitor: compares results on transfers, hold behaviour on stalls
  initial begin
    bit prev_stall = 1'b0;
    logic [RW-1:0] prev_obs = '0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid && observed() == prev_obs, "R1 hold", observed(), prev_obs);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected result", observed(), '0);
          end else begin
            logic [RW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(observed() === e, t, observed(), e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_obs   = observed();
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] CP_SVC = 32'h6000_00D3;
  localparam logic [31:0] CP_IRQ = 32'h2000_0092;
  localparam logic [31:0] CP_FIQ = 32'h8000_00D1;
  localparam logic [31:0] CP_USR = 32'h4000_0010;
  localparam logic [31:0] CP_SYS = 32'h1000_001F;
  localparam logic [31:0] SP_A   = 32'hA5C3_0F13;

  task automatic run_set();
    send("R2 read cpsr",        enc(2'b00, 0, 0, 4'h0, 4'd5, 4'h0, 8'h00), CP_SVC, SP_A, 32'h0);
    send("R3 read spsr irq",    enc(2'b00, 1, 0, 4'h0, 4'd9, 4'h0, 8'h00), CP_IRQ, SP_A, 32'h0);
    send("R3 R10 read spsr usr",enc(2'b00, 1, 0, 4'h0, 4'd1, 4'h0, 8'h00), CP_USR, SP_A, 32'h0);
    send("R4 R7 reg full mask", enc(2'b10, 0, 0, 4'hF, 4'h0, 4'h0, 8'h07), CP_SVC, SP_A, 32'hF000_001F);
    send("R6 R7 flags byte",    enc(2'b10, 0, 0, 4'h8, 4'h0, 4'h0, 8'h03), CP_SVC, SP_A, 32'h1234_5678);
    send("R5 imm rot",          enc(2'b10, 0, 1, 4'h8, 4'h0, 4'h4, 8'hF0), CP_SVC, SP_A, 32'hDEAD_BEEF);
    send("R5 imm no rot",       enc(2'b10, 0, 1, 4'h1, 4'h0, 4'h0, 8'h9B), CP_SVC, SP_A, 32'h0);
    send("R5 imm odd rot",      enc(2'b10, 0, 1, 4'hF, 4'h0, 4'h1, 8'hC3), CP_SVC, SP_A, 32'h0);
    send("R8 user cpsr write",  enc(2'b10, 0, 0, 4'hF, 4'h0, 4'h0, 8'h02), CP_USR, SP_A, 32'h0000_00D3);
    send("R8 R10 user spsr wr", enc(2'b10, 1, 0, 4'hF, 4'h0, 4'h0, 8'h02), CP_USR, SP_A, 32'h1111_1111);
    send("R9 R10 sys spsr wr",  enc(2'b10, 1, 0, 4'hF, 4'h0, 4'h0, 8'h02), CP_SYS, SP_A, 32'h2222_2222);
    send("R7 sys cpsr write",   enc(2'b10, 0, 0, 4'h9, 4'h0, 4'h0, 8'h02), CP_SYS, SP_A, 32'h8000_0012);
    send("R9 R6 fiq spsr mask", enc(2'b10, 1, 0, 4'h6, 4'h0, 4'h0, 8'h02), CP_FIQ, SP_A, 32'h3344_5566);
    send("R6 zero mask",        enc(2'b10, 0, 0, 4'h0, 4'h0, 4'h0, 8'h02), CP_IRQ, SP_A, 32'hFFFF_FFFF);
    send("R11 undef op01",      enc(2'b01, 0, 0, 4'hF, 4'd3, 4'h0, 8'h02), CP_SVC, SP_A, 32'hFFFF_FFFF);
    send("R11 undef op11",      enc(2'b11, 1, 1, 4'hF, 4'd3, 4'h2, 8'h55), CP_USR, SP_A, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12 reset state",
          RW'({out_valid, in_ready}), RW'(2'b01));
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(observed() == '0, "R12 idle outputs zero", observed(), '0);
    run_set();
    stall_mode = 1'b1;
    run_set();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1 drained", RW'(exp_q.size()), '0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule